// File: doc/BRIEF.md
# Memory Bitfield Access Unit

This unit runs one bitfield operation against byte-addressed memory per command. The command gives a base byte address, a signed bit offset counted from the most significant bit of that byte, and a length code. The unit finds the byte that holds the first field bit. It works out how many bytes the field spans and picks a single big-endian access window of 1, 2, 4 or 8 bytes that covers the field. It reads that window, places the field at a known bit position inside a 64-bit image, and then performs the operation.

The operations are unsigned extract, signed extract, insert, invert, clear, set and find-first-one. Insert, invert, clear and set write the modified window back to the same address with the same access size. Extract and find-first-one only read. Every command returns a result word and the original field, left-justified, for use by condition-code logic in a neighbouring block.

The block is used as a helper beside an execution pipeline. A command is accepted while `cmd_ready` is high. The answer appears as a single-cycle `rsp_valid` pulse.

Top module: `bitfield_mem_unit`

## Requirements
- R1: A length code of 0 selects a 32-bit field. Any other code n selects an n-bit field.
- R2: The field starts at bit position base*8 + offset in big-endian bit order, where bit 0 is the most significant bit of byte `base`. The offset is signed, so a negative offset reaches into lower addresses.
- R3: With r = offset mod 8 (0..7) and span = (r + length - 1) / 8, the access size on `mem_bytes` is 1 byte for span 0, 2 for span 1, 4 for spans 2 and 3, and 8 for span 4.
- R4: The access address is base + floor(offset/8). It is lowered by one when span is 2 and that address is odd. When span is 4 it is rounded down to a multiple of 4.
- R5: Op code 0 (unsigned extract) returns the field zero-extended to 32 bits.
- R6: Op code 1 (signed extract) returns the field sign-extended to 32 bits.
- R7: Op code 2 (insert) writes the low `length` bits of `cmd_value` into the field and leaves every other memory bit unchanged. It returns `cmd_value` shifted left by (32 - length).
- R8: Op codes 3, 4 and 5 invert, clear and set every field bit respectively, leaving all other memory bits unchanged. Each returns the original field left-justified in 32 bits.
- R9: Op code 6 (find-first-one) returns offset plus the index of the first set field bit, counted from the field start. It returns offset + length when the field is zero.
- R10: Extracts and find-first-one issue no write. A modifying op issues exactly one write, to the same address and with the same size as its read.
- R11: `rsp_field` carries the original field left-justified, with zeros below it, for every op.
- R12: After reset `cmd_ready` is high and `rsp_valid` and `mem_req` are low. `cmd_ready` stays low from acceptance until the response. Each command gives exactly one `rsp_valid` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Base byte address |
| cmd_offset | input | 32 | Signed bit offset |
| cmd_len | input | 5 | Length code, 0 means 32 |
| cmd_value | input | 32 | Value for insert |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Window start address |
| mem_bytes | output | 4 | Window size in bytes: 1, 2, 4 or 8 |
| mem_wdata | output | 64 | Write data, right-justified big-endian |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Read data, right-justified big-endian, valid with ack |
| rsp_valid | output | 1 | Result pulse |
| rsp_result | output | 32 | Operation result |
| rsp_field | output | 32 | Original field, left-justified |

## Verification
The assertions assume that the memory port returns an acknowledge for every request it is given. They also assume that read data is right-justified in the low `mem_bytes` bytes, and that no command arrives while `cmd_ready` is low. The bench models memory as a zero-wait 256-byte array and only raises `cmd_valid` when the unit is idle. It keeps every field window inside that array, so no access wraps. Expected values come from a bit-by-bit walk of the field in bench memory. That walk is independent of the window and realignment arithmetic the unit uses.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int FIELD_W = 32;
  localparam int IMG_W   = 2 * FIELD_W;
  localparam int LEN_W   = $clog2(FIELD_W) + 1;
  localparam int POS_W   = $clog2(IMG_W);

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6,
    OP_RSV  = 3'd7
  } bf_op_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [POS_W-1:0] cbit;
    logic [3:0]       nbytes;
  } bf_loc_t;

  function automatic logic op_writes(input bf_op_e op);
    return (op == OP_INS) || (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET);
  endfunction
endpackage

// File: rtl/bfm_locate.sv
module bfm_locate
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [31:0]        offset,
  input  logic [LEN_W-2:0]   len_code,
  output logic [ADDR_W-1:0]  acc_addr,
  output bf_loc_t            loc
);
  logic [ADDR_W-1:0] byte_addr;
  logic [2:0]        rbit;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  last_bit;
  logic [2:0]        span;

  always_comb begin
    byte_addr = base + ADDR_W'($signed(offset) >>> 3);
    rbit      = offset[2:0];
    len_eff   = (len_code == '0) ? LEN_W'(FIELD_W) : {1'b0, len_code};
    last_bit  = LEN_W'(rbit) + len_eff - LEN_W'(1);
    span      = last_bit[LEN_W-1:3];

    acc_addr   = byte_addr;
    loc.len    = len_eff;
    loc.cbit   = POS_W'(rbit) + POS_W'(32);
    loc.nbytes = 4'd4;
    case (span)
      3'd0: begin
        loc.cbit   = POS_W'(rbit) + POS_W'(56);
        loc.nbytes = 4'd1;
      end
      3'd1: begin
        loc.cbit   = POS_W'(rbit) + POS_W'(48);
        loc.nbytes = 4'd2;
      end
      3'd2: begin
        if (byte_addr[0]) begin
          acc_addr = byte_addr - ADDR_W'(1);
          loc.cbit = POS_W'(rbit) + POS_W'(40);
        end
      end
      3'd3: ;
      default: begin
        acc_addr   = {byte_addr[ADDR_W-1:2], 2'b00};
        loc.cbit   = POS_W'(rbit) + POS_W'({byte_addr[1:0], 3'b000});
        loc.nbytes = 4'd8;
      end
    endcase
  end
endmodule

// File: rtl/bfm_field_alu.sv
module bfm_field_alu
  import bfm_pkg::*;
(
  input  bf_op_e             op,
  input  bf_loc_t            loc,
  input  logic [IMG_W-1:0]   image,
  input  logic [FIELD_W-1:0] ins_val,
  input  logic [31:0]        offset,
  output logic [IMG_W-1:0]   new_image,
  output logic [FIELD_W-1:0] result,
  output logic [FIELD_W-1:0] field_lj
);
  localparam int SH_W = POS_W + 1;

  logic [IMG_W-1:0]   just;
  logic [IMG_W-1:0]   mask;
  logic [IMG_W-1:0]   ins_img;
  logic [SH_W-1:0]    down;
  logic [FIELD_W-1:0] extu;
  logic [FIELD_W-1:0] exts;
  logic [LEN_W-1:0]   lead;

  function automatic logic [LEN_W-1:0] count_lead(input logic [FIELD_W-1:0] v);
    logic [LEN_W-1:0] n;
    logic             seen;
    n    = '0;
    seen = 1'b0;
    for (int i = FIELD_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      if (!seen) n = n + LEN_W'(1);
    end
    return n;
  endfunction

  always_comb begin
    down     = SH_W'(IMG_W) - SH_W'(loc.len);
    just     = image << loc.cbit;
    mask     = ({IMG_W{1'b1}} << down) >> loc.cbit;
    field_lj = just[IMG_W-1:FIELD_W] & ({FIELD_W{1'b1}} << (LEN_W'(FIELD_W) - loc.len));
    extu     = FIELD_W'(just >> down);
    exts     = FIELD_W'($signed(just) >>> down);
    ins_img  = ({{FIELD_W{1'b0}}, ins_val} << down) >> loc.cbit;
    lead     = (field_lj == '0) ? loc.len : count_lead(field_lj);

    new_image = image;
    result    = extu;
    case (op)
      OP_EXTS: result = exts;
      OP_INS: begin
        new_image = (image & ~mask) | ins_img;
        result    = ins_val << (LEN_W'(FIELD_W) - loc.len);
      end
      OP_CHG: begin
        new_image = image ^ mask;
        result    = field_lj;
      end
      OP_CLR: begin
        new_image = image & ~mask;
        result    = field_lj;
      end
      OP_SET: begin
        new_image = image | mask;
        result    = field_lj;
      end
      OP_FFO:  result = offset + FIELD_W'(lead);
      default: result = extu;
    endcase
  end
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_offset,
  input  logic [4:0]        cmd_len,
  input  logic [31:0]       cmd_value,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_bytes,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_result,
  output logic [31:0]       rsp_field
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} st_e;

  st_e                st_q;
  logic [ADDR_W-1:0]  addr_q;
  bf_loc_t            loc_q;
  bf_op_e             op_q;
  logic [31:0]        val_q;
  logic [31:0]        off_q;
  logic [IMG_W-1:0]   img_q;
  logic               rsp_valid_q;
  logic [31:0]        rsp_result_q;
  logic [31:0]        rsp_field_q;

  logic [ADDR_W-1:0]  loc_addr;
  bf_loc_t            loc_d;
  logic [IMG_W-1:0]   alu_img;
  logic [FIELD_W-1:0] alu_res;
  logic [FIELD_W-1:0] alu_field;
  logic [IMG_W-1:0]   rd_keep;

  bfm_locate #(.ADDR_W(ADDR_W)) i_locate (
    .base     (cmd_addr),
    .offset   (cmd_offset),
    .len_code (cmd_len),
    .acc_addr (loc_addr),
    .loc      (loc_d)
  );

  bfm_field_alu i_alu (
    .op        (op_q),
    .loc       (loc_q),
    .image     (img_q),
    .ins_val   (val_q),
    .offset    (off_q),
    .new_image (alu_img),
    .result    (alu_res),
    .field_lj  (alu_field)
  );

  assign rd_keep = {IMG_W{1'b1}} >> (7'd64 - {loc_q.nbytes, 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      addr_q       <= '0;
      loc_q        <= '0;
      op_q         <= OP_EXTU;
      val_q        <= '0;
      off_q        <= '0;
      img_q        <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_result_q <= '0;
      rsp_field_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            addr_q <= loc_addr;
            loc_q  <= loc_d;
            op_q   <= bf_op_e'(cmd_op);
            val_q  <= cmd_value;
            off_q  <= cmd_offset;
            st_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            img_q <= mem_rdata & rd_keep;
            st_q  <= op_writes(op_q) ? ST_WRITE : ST_RESP;
          end
        end
        ST_WRITE: begin
          if (mem_ack) st_q <= ST_RESP;
        end
        default: begin
          rsp_valid_q  <= 1'b1;
          rsp_result_q <= alu_res;
          rsp_field_q  <= alu_field;
          st_q         <= ST_IDLE;
        end
      endcase
    end
  end

  assign cmd_ready  = (st_q == ST_IDLE);
  assign mem_req    = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we     = (st_q == ST_WRITE);
  assign mem_addr   = addr_q;
  assign mem_bytes  = loc_q.nbytes;
  assign mem_wdata  = alu_img & rd_keep;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_result = rsp_result_q;
  assign rsp_field  = rsp_field_q;

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($onehot(mem_bytes) && mem_bytes != 4'd0)) else $error("size");  // R3
  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_bytes == 4'd8) |-> (mem_addr[1:0] == 2'b00)) else $error("align");  // R4
  AST_WRITE_SAME_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($past(mem_req) && $stable(mem_addr) && $stable(mem_bytes))) else $error("rmw");  // R10
  AST_READONLY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> op_writes(op_q)) else $error("ro write");  // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid) else $error("pulse");  // R12
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready) else $error("ready");  // R12
  AST_FFO_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESP && op_q == OP_FFO) |-> ((alu_res - off_q) <= 32'(loc_q.len))) else $error("ffo");  // R9
endmodule

// File: tb/test_bitfield_mem_unit.sv
module test_bitfield_mem_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_addr = 32'd0;
  logic [31:0] cmd_offset = 32'd0;
  logic [4:0]  cmd_len = 5'd0;
  logic [31:0] cmd_value = 32'd0;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_bytes;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_result;
  logic [31:0] rsp_field;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] mem_b [256];
  logic [7:0] exp_b [256];

  int          rd_count, wr_count;
  logic [31:0] rd_addr_seen, wr_addr_seen;
  logic [3:0]  rd_size_seen, wr_size_seen;

  always #4 clk = ~clk;

  bitfield_mem_unit i_bitfield_mem_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_offset(cmd_offset),
    .cmd_len(cmd_len), .cmd_value(cmd_value), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_field(rsp_field)
  );

  assign mem_ack = mem_req;

  always_comb begin
    mem_rdata = 64'd0;
    for (int k = 0; k < 8; k++)
      if (k < int'(mem_bytes))
        mem_rdata = {mem_rdata[55:0], mem_b[8'(mem_addr + 32'(k))]};
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        wr_count     <= wr_count + 1;
        wr_addr_seen <= mem_addr;
        wr_size_seen <= mem_bytes;
        for (int k = 0; k < 8; k++)
          if (k < int'(mem_bytes))
            mem_b[8'(mem_addr + 32'(k))] <= mem_wdata[8*(int'(mem_bytes)-1-k) +: 8];
      end else begin
        rd_count     <= rd_count + 1;
        rd_addr_seen <= mem_addr;
        rd_size_seen <= mem_bytes;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint bit_at(input logic [31:0] base, input int off, input int i);
    return longint'(base) * 64'sd8 + longint'(off) + longint'(i);
  endfunction

  function automatic logic get_bit(input longint ba);
    return exp_b[8'(ba >>> 3)][7 - int'(ba & 64'sd7)];
  endfunction

  task automatic put_bit(input longint ba, input logic v);
    exp_b[8'(ba >>> 3)][7 - int'(ba & 64'sd7)] = v;
  endtask

  task automatic fill_mem(input int seed);
    for (int k = 0; k < 256; k++) mem_b[k] = 8'(k * 37 + seed * 11 + 5);
  endtask

  // Runs one command, computes the expected outcome bit by bit, checks everything.
  task automatic run_op(input string req, input int op, input logic [31:0] base,
                        input int off, input logic [4:0] lcode, input logic [31:0] val);
    int          L, bo, sp, wait_n, first;
    longint      a;
    logic [31:0] flj, exp_res, exp_addr;
    logic [3:0]  exp_size;
    int          rd0, wr0;
    @(negedge clk);
    for (int k = 0; k < 256; k++) exp_b[k] = mem_b[k];
    L = (lcode == 5'd0) ? 32 : int'(lcode);
    flj = 32'd0;
    first = -1;
    for (int i = 0; i < L; i++) begin
      flj[31-i] = get_bit(bit_at(base, off, i));
      if (flj[31-i] && first < 0) first = i;
    end
    bo = off & 7;
    sp = (bo + L - 1) / 8;
    a  = longint'(base) + longint'(off >>> 3);
    exp_size = (sp == 0) ? 4'd1 : (sp == 1) ? 4'd2 : (sp == 4) ? 4'd8 : 4'd4;
    if (sp == 2 && a[0]) a = a - 1;
    if (sp == 4) a = a & ~64'sd3;
    exp_addr = a[31:0];
    case (op)
      1: exp_res = 32'($signed(flj) >>> (32 - L));
      2: begin
        exp_res = val << (32 - L);
        for (int i = 0; i < L; i++) put_bit(bit_at(base, off, i), val[L-1-i]);
      end
      3, 4, 5: begin
        exp_res = flj;
        for (int i = 0; i < L; i++)
          put_bit(bit_at(base, off, i), (op == 3) ? ~flj[31-i] : (op == 5));
      end
      6: exp_res = 32'(off + ((first < 0) ? L : first));
      default: exp_res = flj >> (32 - L);
    endcase
    rd0 = rd_count;
    wr0 = wr_count;
    cmd_op = 3'(op); cmd_addr = base; cmd_offset = 32'(off); cmd_len = lcode;
    cmd_value = val; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R12", "ready low while busy", 64'(cmd_ready), 64'd0);
    wait_n = 0;
    while (!rsp_valid && wait_n < 50) begin
      @(negedge clk);
      wait_n++;
    end
    check("R12", "response arrived", 64'(rsp_valid), 64'd1);
    check(req, "result", 64'(rsp_result), 64'(exp_res));
    check("R11", "field image", 64'(rsp_field), 64'(flj));
    check("R3", "access size", 64'(rd_size_seen), 64'(exp_size));
    check("R4", "access address", 64'(rd_addr_seen), 64'(exp_addr));
    check("R10", "one read", 64'(rd_count - rd0), 64'd1);
    if (op >= 2 && op <= 5) begin
      check("R10", "one write", 64'(wr_count - wr0), 64'd1);
      check("R10", "write address", 64'(wr_addr_seen), 64'(exp_addr));
      check("R10", "write size", 64'(wr_size_seen), 64'(exp_size));
    end else begin
      check("R10", "no write", 64'(wr_count - wr0), 64'd0);
    end
    begin
      int bad = 0;
      for (int k = 0; k < 256; k++) if (mem_b[k] !== exp_b[k]) bad++;
      check(req, "memory image mismatching bytes", 64'(bad), 64'd0);
    end
    @(negedge clk);
    check("R12", "single pulse", 64'(rsp_valid), 64'd0);
    check("R12", "ready again", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R12", "reset ready", 64'(cmd_ready), 64'd1);
    check("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R12", "reset mem_req", 64'(mem_req), 64'd0);
  endtask

  task automatic t_extract;
    fill_mem(1);
    run_op("R5", 0, 32'd40, 3, 5'd5, 32'd0);
    mem_b[40] = 8'h10;
    run_op("R6", 1, 32'd40, 3, 5'd5, 32'd0);
    run_op("R5", 0, 32'd40, 3, 5'd5, 32'd0);
    run_op("R1", 0, 32'd64, 4, 5'd0, 32'd0);
    run_op("R1", 1, 32'd64, 0, 5'd0, 32'd0);
    run_op("R6", 1, 32'd70, 9, 5'd17, 32'd0);
  endtask

  task automatic t_negative;
    fill_mem(2);
    run_op("R2", 0, 32'd50, -3, 5'd7, 32'd0);
    run_op("R2", 1, 32'd90, -21, 5'd12, 32'd0);
    run_op("R2", 5, 32'd120, -1, 5'd1, 32'd0);
  endtask

  task automatic t_windows;
    fill_mem(3);
    run_op("R3", 0, 32'd20, 6, 5'd5, 32'd0);
    run_op("R4", 0, 32'd33, 2, 5'd20, 32'd0);
    run_op("R4", 3, 32'd33, 2, 5'd20, 32'd0);
    run_op("R3", 0, 32'd36, 1, 5'd26, 32'd0);
    run_op("R4", 0, 32'd45, 7, 5'd30, 32'd0);
    run_op("R4", 4, 32'd47, 5, 5'd0, 32'd0);
  endtask

  task automatic t_insert;
    fill_mem(4);
    run_op("R7", 2, 32'd100, 5, 5'd9, 32'hFFFF_FE5A);
    run_op("R7", 2, 32'd110, 12, 5'd0, 32'hDEAD_BEEF);
    run_op("R7", 2, 32'd131, -2, 5'd1, 32'h0000_0001);
  endtask

  task automatic t_modify;
    fill_mem(5);
    run_op("R8", 3, 32'd140, 3, 5'd11, 32'd0);
    run_op("R8", 4, 32'd150, 7, 5'd24, 32'd0);
    run_op("R8", 5, 32'd161, 1, 5'd30, 32'd0);
  endtask

  task automatic t_ffo;
    fill_mem(6);
    mem_b[180] = 8'h00; mem_b[181] = 8'h04; mem_b[182] = 8'h00;
    run_op("R9", 6, 32'd180, 2, 5'd16, 32'd0);
    run_op("R9", 6, 32'd180, 1, 5'd6, 32'd0);
    run_op("R9", 6, 32'd182, -12, 5'd9, 32'd0);
    run_op("R9", 6, 32'd190, 0, 5'd0, 32'd0);
  endtask

  initial begin
    rd_count = 0; wr_count = 0;
    rd_addr_seen = '0; wr_addr_seen = '0; rd_size_seen = '0; wr_size_seen = '0;
    fill_mem(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_extract();
    t_negative();
    t_windows();
    t_insert();
    t_modify();
    t_ffo();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule